// File: doc/BRIEF.md
# Return-Address Shadow Stack Guard

This block keeps a hardware shadow stack of return addresses for a 64-bit core. It holds the shadow stack pointer and runs two shadow operations against a simple single-beat memory port. A push writes a link-register value into the next slot below the pointer. A pop-check reads the top slot and compares it with the link-register value the core supplies.

The same unit also carries the core's ordinary loads and stores. Every access arrives with the permission bits of its target page. The unit classifies the page and decides whether to issue the access or to report a fault. Pages with a write-only encoding hold shadow stacks. Only shadow operations may write them, and ordinary loads may still read them.

One operation is in flight at a time. A fault found at request time is reported in the cycle the request is accepted, and no memory access is made. An access that reaches memory reports its result in the cycle its response arrives. A faulting operation never moves the pointer. Software can load the pointer directly to switch to another shadow stack.

Top module: `rstk_guard`

## Requirements
- R1: The permission input is ordered as bit 0 = readable, bit 1 = writable, bit 2 = executable. The encoding readable=0, writable=1, executable=0 marks a shadow-stack page, and shadow operations on such a page proceed without fault.
- R2: A push (op_kind 0) on a shadow-stack page issues a memory write of op_data to address pointer−8. When the response arrives, the result carries no exception and the pointer becomes pointer−8.
- R3: A pop-check (op_kind 1) issues a memory read at the pointer. If the returned word equals op_data, the result carries no exception and the pointer becomes pointer+8.
- R4: If a pop-check's returned word differs from op_data in any bit, the result is an exception with cause 18 and trap value 3, and the pointer is unchanged.
- R5: A regular store (op_kind 3) to a shadow-stack page is refused with a store access fault: cause 7, trap value = op_addr, and no memory request.
- R6: A regular load (op_kind 2) from a shadow-stack page or a readable page issues a read at op_addr and returns the response data. A load from any other non-readable page gets a load page fault: cause 13, trap value = op_addr.
- R7: A push or pop-check to a page that is readable but not writable, or to any other non-shadow page that is not readable, gets a store/AMO page fault. The cause is 15, the trap value is the target slot address, no memory request is made and the pointer is unchanged.
- R8: A push or pop-check to a readable and writable page, with or without execute, gets a store access fault. The cause is 7, the trap value is the target slot address, and no memory request is made.
- R9: A regular store to a readable and writable page issues a memory write of op_data at op_addr. A store to a page without write permission gets cause 15.
- R10: When ssp_wr_en is high and no access is outstanding, the pointer takes ssp_wr_data at the next edge and op_ready is low in that cycle. While an access is outstanding, ssp_wr_en has no effect.
- R11: Only one operation is outstanding at a time. op_ready stays low and no new memory request is made from acceptance until the response. res_valid rises only in the accept cycle of a fault or in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Unit can accept an operation this cycle |
| op_kind | input | 2 | 0 push, 1 pop-check, 2 load, 3 store |
| op_addr | input | 64 | Address of a regular load or store |
| op_data | input | 64 | Link value for push and pop-check, or store data |
| page_perm | input | 3 | Permission bits of the target page {X,W,R} |
| ssp_wr_en | input | 1 | Load the shadow stack pointer |
| ssp_wr_data | input | 64 | New shadow stack pointer |
| ssp_q | output | 64 | Current shadow stack pointer |
| mem_req_valid | output | 1 | Memory request strobe |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 64 | Request address |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_rdata | input | 64 | Response read data |
| res_valid | output | 1 | Operation result valid |
| res_rdata | output | 64 | Data read by a load or pop-check |
| res_exc | output | 1 | Result is an exception |
| res_cause | output | 5 | Exception cause |
| res_tval | output | 64 | Exception trap value |

## Verification
The embedded properties guard, on every cycle, the rules that hold at each edge. Nothing leaves while an access is outstanding. Every exception leaves the pointer as it was. A successful push moves the pointer down by one slot. No ordinary store is ever sent to a write-only page. A software-check exception always carries trap value 3. Only the directed scenarios can show the full fault table across permission encodings, the exact request addresses and data, and the compare result for mismatches in high and low bits. They also cover the pointer following a sequence of pushes and pops, and a pointer write being dropped during a wait.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
   typedef enum logic [1:0] {
      OPK_PUSH   = 2'd0,
      OPK_POPCHK = 2'd1,
      OPK_LOAD   = 2'd2,
      OPK_STORE  = 2'd3
   } opk_e;

   typedef enum logic [1:0] {
      PG_SHADOW,
      PG_RDONLY,
      PG_RDWR,
      PG_OTHER
   } pgcls_e;

   typedef enum logic {
      ST_IDLE,
      ST_WAIT
   } rstk_state_e;

   localparam int unsigned CAUSE_LD_PF  = 13;
   localparam int unsigned CAUSE_ST_AF  = 7;
   localparam int unsigned CAUSE_ST_PF  = 15;
   localparam int unsigned CAUSE_SWCHK  = 18;
   localparam int unsigned TVAL_SSCHK   = 3;
endpackage

// File: rtl/rstk_perm_check.sv
module rstk_perm_check
   import rstk_pkg::*;
#(
   parameter int unsigned CAUSE_W = 5
) (
   input  opk_e               kind,
   input  logic [2:0]         perm,
   output pgcls_e             cls,
   output logic               flt,
   output logic [CAUSE_W-1:0] flt_cause
);
   localparam int unsigned PR = 0;
   localparam int unsigned PW = 1;
   localparam int unsigned PX = 2;

   if (CAUSE_W < 5) begin : g_bad_cause_w
      $error("CAUSE_W must hold cause 18");
   end

   always_comb begin
      if (!perm[PR] && perm[PW] && !perm[PX]) cls = PG_SHADOW;
      else if (perm[PR] && !perm[PW])         cls = PG_RDONLY;
      else if (perm[PR] && perm[PW])          cls = PG_RDWR;
      else                                    cls = PG_OTHER;
   end

   always_comb begin
      flt       = 1'b0;
      flt_cause = '0;
      unique case (kind)
         OPK_PUSH, OPK_POPCHK: begin
            if (cls == PG_RDWR) begin
               flt       = 1'b1;
               flt_cause = CAUSE_W'(CAUSE_ST_AF);
            end else if (cls != PG_SHADOW) begin
               flt       = 1'b1;
               flt_cause = CAUSE_W'(CAUSE_ST_PF);
            end
         end
         OPK_LOAD: begin
            if (!perm[PR] && cls != PG_SHADOW) begin
               flt       = 1'b1;
               flt_cause = CAUSE_W'(CAUSE_LD_PF);
            end
         end
         OPK_STORE: begin
            if (cls == PG_SHADOW) begin
               flt       = 1'b1;
               flt_cause = CAUSE_W'(CAUSE_ST_AF);
            end else if (cls != PG_RDWR) begin
               flt       = 1'b1;
               flt_cause = CAUSE_W'(CAUSE_ST_PF);
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rstk_lane_cmp.sv
module rstk_lane_cmp #(
   parameter int unsigned W      = 64,
   parameter int unsigned LANE_W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         eq
);
   localparam int unsigned NLANE = (LANE_W > 0 && W % LANE_W == 0) ? W / LANE_W : 1;

   if (LANE_W == 0) begin : g_bad_lane
      $error("LANE_W must be non-zero");
   end

   if (NLANE > 1) begin : g_lanes
      logic [NLANE-1:0] lane_eq;
      for (genvar i = 0; i < NLANE; i++) begin : g_lane
         assign lane_eq[i] = (a[i*LANE_W +: LANE_W] == b[i*LANE_W +: LANE_W]);
      end
      assign eq = &lane_eq;
   end else begin : g_flat
      assign eq = (a == b);
   end
endmodule

// File: rtl/rstk_ptr.sv
module rstk_ptr #(
   parameter int unsigned   XLEN    = 64,
   parameter logic [63:0]   SSP_RST = 64'h0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [XLEN-1:0] wr_data,
   input  logic            dec_en,
   input  logic            inc_en,
   output logic [XLEN-1:0] ssp_q,
   output logic [XLEN-1:0] ssp_dn
);
   localparam logic [XLEN-1:0] SLOT = XLEN'(XLEN / 8);

   assign ssp_dn = ssp_q - SLOT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ssp_q <= SSP_RST[XLEN-1:0];
      else if (wr_en)  ssp_q <= wr_data;
      else if (dec_en) ssp_q <= ssp_dn;
      else if (inc_en) ssp_q <= ssp_q + SLOT;
   end

   AST_PTR_ONE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_en && inc_en)); // R3
endmodule

// File: rtl/rstk_guard.sv
module rstk_guard
   import rstk_pkg::*;
#(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned CAUSE_W = 5,
   parameter int unsigned LANE_W  = 16,
   parameter logic [63:0] SSP_RST = 64'h0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   output logic               op_ready,
   input  logic [1:0]         op_kind,
   input  logic [XLEN-1:0]    op_addr,
   input  logic [XLEN-1:0]    op_data,
   input  logic [2:0]         page_perm,
   input  logic               ssp_wr_en,
   input  logic [XLEN-1:0]    ssp_wr_data,
   output logic [XLEN-1:0]    ssp_q,
   output logic               mem_req_valid,
   output logic               mem_req_write,
   output logic [XLEN-1:0]    mem_req_addr,
   output logic [XLEN-1:0]    mem_req_wdata,
   input  logic               mem_rsp_valid,
   input  logic [XLEN-1:0]    mem_rsp_rdata,
   output logic               res_valid,
   output logic [XLEN-1:0]    res_rdata,
   output logic               res_exc,
   output logic [CAUSE_W-1:0] res_cause,
   output logic [XLEN-1:0]    res_tval
);
   localparam logic [XLEN-1:0] SLOT = XLEN'(XLEN / 8);

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("XLEN must be 32 or 64");
   end

   rstk_state_e        st_q;
   opk_e               kind_in, kind_q;
   logic [XLEN-1:0]    data_q;
   logic [XLEN-1:0]    ssp_dn, tgt_addr;
   pgcls_e             pg_cls;
   logic               flt;
   logic [CAUSE_W-1:0] flt_cause;
   logic               accept, acc_flt, rsp_done, cmp_eq, mism;

   assign kind_in  = opk_e'(op_kind);
   assign op_ready = (st_q == ST_IDLE) && !ssp_wr_en;
   assign accept   = op_valid && op_ready;

   always_comb begin
      unique case (kind_in)
         OPK_PUSH:   tgt_addr = ssp_dn;
         OPK_POPCHK: tgt_addr = ssp_q;
         default:    tgt_addr = op_addr;
      endcase
   end

   rstk_perm_check #(.CAUSE_W(CAUSE_W)) perm_i (
      .kind      (kind_in),
      .perm      (page_perm),
      .cls       (pg_cls),
      .flt       (flt),
      .flt_cause (flt_cause)
   );

   rstk_lane_cmp #(.W(XLEN), .LANE_W(LANE_W)) cmp_i (
      .a  (mem_rsp_rdata),
      .b  (data_q),
      .eq (cmp_eq)
   );

   assign acc_flt  = accept && flt;
   assign rsp_done = (st_q == ST_WAIT) && mem_rsp_valid;
   assign mism     = rsp_done && (kind_q == OPK_POPCHK) && !cmp_eq;

   rstk_ptr #(.XLEN(XLEN), .SSP_RST(SSP_RST)) ptr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ssp_wr_en && (st_q == ST_IDLE)),
      .wr_data (ssp_wr_data),
      .dec_en  (rsp_done && (kind_q == OPK_PUSH)),
      .inc_en  (rsp_done && (kind_q == OPK_POPCHK) && cmp_eq),
      .ssp_q   (ssp_q),
      .ssp_dn  (ssp_dn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= OPK_LOAD;
         data_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (accept && !flt) begin
               st_q   <= ST_WAIT;
               kind_q <= kind_in;
               data_q <= op_data;
            end
            ST_WAIT: if (mem_rsp_valid) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid = accept && !flt;
   assign mem_req_write = (kind_in == OPK_PUSH) || (kind_in == OPK_STORE);
   assign mem_req_addr  = tgt_addr;
   assign mem_req_wdata = op_data;

   assign res_valid = acc_flt || rsp_done;
   assign res_exc   = acc_flt || mism;
   assign res_rdata = rsp_done ? mem_rsp_rdata : '0;

   always_comb begin
      if (acc_flt) begin
         res_cause = flt_cause;
         res_tval  = tgt_addr;
      end else if (mism) begin
         res_cause = CAUSE_W'(CAUSE_SWCHK);
         res_tval  = XLEN'(TVAL_SSCHK);
      end else begin
         res_cause = '0;
         res_tval  = '0;
      end
   end

   AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT) |-> (!op_ready && !mem_req_valid)); // R11
   AST_FAULT_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_exc) |=> (ssp_q == $past(ssp_q))); // R4
   AST_PUSH_MOVES_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && kind_q == OPK_PUSH) |=> (ssp_q == $past(ssp_q) - SLOT)); // R2
   AST_NO_PLAIN_WRITE_TO_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write && pg_cls == PG_SHADOW) |-> (kind_in == OPK_PUSH)); // R5
   AST_SWCHK_TVAL: assert property (@(posedge clk) disable iff (!rst_n)
      (res_exc && res_cause == CAUSE_W'(CAUSE_SWCHK)) |-> (res_tval == XLEN'(TVAL_SSCHK))); // R4
endmodule

// File: tb/rstk_guard_tb.sv
`timescale 1ns/1ps
module rstk_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_ready;
   logic [1:0]  op_kind = 2'd0;
   logic [63:0] op_addr = '0, op_data = '0;
   logic [2:0]  page_perm = 3'b000;
   logic        ssp_wr_en = 1'b0;
   logic [63:0] ssp_wr_data = '0;
   logic [63:0] ssp_q;
   logic        mem_req_valid, mem_req_write;
   logic [63:0] mem_req_addr, mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_rdata = '0;
   logic        res_valid, res_exc;
   logic [63:0] res_rdata, res_tval;
   logic [4:0]  res_cause;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   rstk_guard dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data), .page_perm(page_perm),
      .ssp_wr_en(ssp_wr_en), .ssp_wr_data(ssp_wr_data), .ssp_q(ssp_q),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .res_valid(res_valid), .res_rdata(res_rdata), .res_exc(res_exc),
      .res_cause(res_cause), .res_tval(res_tval)
   );

   // observations of the last operation
   logic        o_ready, o_req, o_wr, o_rv, o_exc, o_busy_ok;
   logic [63:0] o_addr, o_wdata, o_rdata, o_tval;
   logic [4:0]  o_cause;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] kind, input logic [63:0] addr, input logic [63:0] data,
                         input logic [2:0] perm, input int dly, input logic [63:0] rsp,
                         input logic poke);
      @(negedge clk);
      op_valid = 1'b1; op_kind = kind; op_addr = addr; op_data = data; page_perm = perm;
      #1;
      o_ready = op_ready; o_req = mem_req_valid; o_wr = mem_req_write;
      o_addr = mem_req_addr; o_wdata = mem_req_wdata;
      o_rv = res_valid; o_exc = res_exc; o_cause = res_cause; o_tval = res_tval; o_rdata = '0;
      o_busy_ok = 1'b1;
      @(posedge clk); #1;
      op_valid = 1'b0; page_perm = 3'b000;
      if (o_req) begin
         for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            op_valid = 1'b1; op_kind = 2'd2; page_perm = 3'b001;
            if (poke && i == 0) begin ssp_wr_en = 1'b1; ssp_wr_data = 64'h5555; end
            #1;
            if (op_ready || mem_req_valid || res_valid) o_busy_ok = 1'b0;
            @(posedge clk); #1;
            op_valid = 1'b0; ssp_wr_en = 1'b0; page_perm = 3'b000;
         end
         @(negedge clk);
         mem_rsp_valid = 1'b1; mem_rsp_rdata = rsp;
         #1;
         o_rv = res_valid; o_exc = res_exc; o_cause = res_cause; o_tval = res_tval; o_rdata = res_rdata;
         @(posedge clk); #1;
         mem_rsp_valid = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R10 reset ssp", ssp_q, 64'h0);
      chk("R11 reset ready", {63'b0, op_ready}, 64'd1);
      chk("R11 reset res_valid", {63'b0, res_valid}, 64'd0);
   endtask

   task automatic t_ssp_write;
      @(negedge clk);
      ssp_wr_en = 1'b1; ssp_wr_data = 64'h1000; #1;
      chk("R10 ready low during write", {63'b0, op_ready}, 64'd0);
      @(posedge clk); #1; ssp_wr_en = 1'b0;
      @(negedge clk);
      chk("R10 ssp loaded", ssp_q, 64'h1000);
   endtask

   task automatic t_push;
      run_op(2'd0, 64'h0, 64'hAAAA_0000_1111_2222, 3'b010, 0, 64'h0, 1'b0);
      chk("R2 push req", {62'b0, o_req, o_wr}, 64'd3);
      chk("R2 push addr", o_addr, 64'h0FF8);
      chk("R2 push wdata", o_wdata, 64'hAAAA_0000_1111_2222);
      chk("R1 push shadow page no exc", {62'b0, o_rv, o_exc}, 64'd2);
      chk("R2 ssp after push", ssp_q, 64'h0FF8);
      run_op(2'd0, 64'h0, 64'hBBBB_3333, 3'b010, 3, 64'h0, 1'b0);
      chk("R11 busy while waiting", {63'b0, o_busy_ok}, 64'd1);
      chk("R2 second push addr", o_addr, 64'h0FF0);
      chk("R2 ssp after 2 pushes", ssp_q, 64'h0FF0);
   endtask

   task automatic t_pop;
      run_op(2'd1, 64'h0, 64'hBBBB_3333, 3'b010, 1, 64'hBBBB_3333, 1'b0);
      chk("R3 pop req read", {62'b0, o_req, o_wr}, 64'd2);
      chk("R3 pop addr", o_addr, 64'h0FF0);
      chk("R3 pop ok", {62'b0, o_rv, o_exc}, 64'd2);
      chk("R3 pop rdata", o_rdata, 64'hBBBB_3333);
      chk("R3 ssp after pop", ssp_q, 64'h0FF8);
   endtask

   task automatic t_pop_mismatch;
      run_op(2'd1, 64'h0, 64'hAAAA_0000_1111_2222, 3'b010, 0, 64'hAAAB_0000_1111_2222, 1'b0);
      chk("R4 high mismatch exc", {62'b0, o_rv, o_exc}, 64'd3);
      chk("R4 cause", {59'b0, o_cause}, 64'd18);
      chk("R4 tval", o_tval, 64'd3);
      chk("R4 ssp kept", ssp_q, 64'h0FF8);
      run_op(2'd1, 64'h0, 64'hAAAA_0000_1111_2222, 3'b010, 0, 64'hAAAA_0000_1111_2223, 1'b0);
      chk("R4 low mismatch exc", {63'b0, o_exc}, 64'd1);
      chk("R4 ssp kept 2", ssp_q, 64'h0FF8);
      run_op(2'd1, 64'h0, 64'hAAAA_0000_1111_2222, 3'b010, 0, 64'hAAAA_0000_1111_2222, 1'b0);
      chk("R3 final pop ok", {63'b0, o_exc}, 64'd0);
      chk("R3 ssp back", ssp_q, 64'h1000);
   endtask

   task automatic t_shadow_faults;
      run_op(2'd0, 64'h0, 64'h1, 3'b001, 0, 64'h0, 1'b0);
      chk("R7 push rdonly no req", {63'b0, o_req}, 64'd0);
      chk("R7 push rdonly cause", {59'b0, o_cause}, 64'd15);
      chk("R7 push rdonly tval", o_tval, 64'h0FF8);
      chk("R7 ssp kept", ssp_q, 64'h1000);
      run_op(2'd1, 64'h0, 64'h1, 3'b101, 0, 64'h0, 1'b0);
      chk("R7 pop rx cause", {59'b0, o_cause}, 64'd15);
      chk("R7 pop rx tval", o_tval, 64'h1000);
      run_op(2'd1, 64'h0, 64'h1, 3'b110, 0, 64'h0, 1'b0);
      chk("R7 pop wx reserved cause", {59'b0, o_cause}, 64'd15);
      run_op(2'd0, 64'h0, 64'h1, 3'b011, 0, 64'h0, 1'b0);
      chk("R8 push rw exc", {61'b0, o_req, o_rv, o_exc}, 64'd3);
      chk("R8 push rw cause", {59'b0, o_cause}, 64'd7);
      chk("R8 push rw tval", o_tval, 64'h0FF8);
      run_op(2'd1, 64'h0, 64'h1, 3'b111, 0, 64'h0, 1'b0);
      chk("R8 pop rwx cause", {59'b0, o_cause}, 64'd7);
      chk("R8 ssp kept", ssp_q, 64'h1000);
   endtask

   task automatic t_regular;
      run_op(2'd3, 64'h2000, 64'h77, 3'b010, 0, 64'h0, 1'b0);
      chk("R5 store shadow no req", {63'b0, o_req}, 64'd0);
      chk("R5 store shadow exc", {62'b0, o_rv, o_exc}, 64'd3);
      chk("R5 store shadow cause", {59'b0, o_cause}, 64'd7);
      chk("R5 store shadow tval", o_tval, 64'h2000);
      run_op(2'd2, 64'h2008, 64'h0, 3'b010, 2, 64'hD00D, 1'b0);
      chk("R6 load shadow req", {62'b0, o_req, o_wr}, 64'd2);
      chk("R6 load shadow addr", o_addr, 64'h2008);
      chk("R6 load shadow data", o_rdata, 64'hD00D);
      chk("R6 load shadow no exc", {63'b0, o_exc}, 64'd0);
      run_op(2'd2, 64'h3000, 64'h0, 3'b100, 0, 64'h0, 1'b0);
      chk("R6 load xonly cause", {59'b0, o_cause}, 64'd13);
      chk("R6 load xonly tval", o_tval, 64'h3000);
      run_op(2'd3, 64'h4000, 64'h99, 3'b011, 0, 64'h0, 1'b0);
      chk("R9 store rw req", {62'b0, o_req, o_wr}, 64'd3);
      chk("R9 store rw wdata", o_wdata, 64'h99);
      chk("R9 store rw ok", {63'b0, o_exc}, 64'd0);
      run_op(2'd3, 64'h4008, 64'h99, 3'b001, 0, 64'h0, 1'b0);
      chk("R9 store rdonly cause", {59'b0, o_cause}, 64'd15);
   endtask

   task automatic t_write_ignored;
      run_op(2'd0, 64'h0, 64'h42, 3'b010, 2, 64'h0, 1'b1);
      chk("R10 write during wait ignored", ssp_q, 64'h0FF8);
      chk("R11 busy with poke", {63'b0, o_busy_ok}, 64'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_ssp_write();
      t_push();
      t_pop();
      t_pop_mismatch();
      t_shadow_faults();
      t_regular();
      t_write_ignored();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule